// File: doc/BRIEF.md
# Three-Backplane Multiplexed LCD Segment Driver

This block produces the drive timing for a 1:3 multiplexed liquid-crystal panel with three common (backplane) lines and twelve segment lines. It takes a four-digit BCD reading, a two-bit decimal-point code, a sign bit, three status flags and a logic-probe mode. From these it emits a two-bit level code per line. The code names one of four drive voltages (V0 lowest to V3 highest) that an analog stage outside this block produces. It also emits a square wave for static annunciators and a buzzer tone.

Each frame has three slots, one per backplane. Every second frame inverts, so no segment sees a DC bias. The segment lines pack the digit segments, the decimal points and the status marks into a fixed line/slot map. In logic-probe mode the panel shows "OL". The two decimal-point inputs then drive the high and low marks, and the low mark also sounds the buzzer.

Top module: `lcd_tri_mux`

## Requirements
- R1: While `rst` is high, the timing is held at slot 0 of a positive frame and `buzz_out` is 0. After the first clock edge with `rst` low, timing advances by one clock cycle per edge.
- R2: Each backplane is selected for SLOT_CYCLES (default 40) clocks, in the order 0, 1, 2. The frame polarity inverts every 3*SLOT_CYCLES clocks. One full drive period is 6*SLOT_CYCLES clocks, which is the clock divided by 240 at the defaults.
- R3: A backplane code is 3 while its slot is active and 1 while it is idle in a positive frame. In a negative frame these become 0 and 2.
- R4: A segment code is 0 for on and 2 for off in a positive frame, and 3 for on and 1 for off in a negative frame. In `seg_code`, line L occupies bits [2L+1:2L], and in `bp_code`, backplane K occupies bits [2K+1:2K].
- R5: The line map lists the mark for slots 0/1/2 on each line. Line 0: low, minus, e of the leading digit. Line 1: a/g/d of the leading digit. Line 2: b/c of the leading digit, then the third decimal point. The remaining digits use lines 3-5, 6-8 and 9-11. Each group holds: mark/f/e, then a/g/d, then b/c/extra. The mark is high, over, peak, and the extra is dp2, dp1, battery, in that group order.
- R6: The BCD digits are `bcd_in[11:8]`, `[7:4]` and `[3:0]`. Each shows the usual seven-segment pattern for 0-9 and is blank for codes 10-15.
- R7: The leading digit `bcd_in[15:12]` shows 1, 2 or 3 and is blank for 0 and for any code above 3.
- R8: In normal mode, `dp_sel` 00 lights no point, 01 lights dp1 (reading xxx.x), 10 lights dp2 (xx.xx), and 11 lights dp3 (x.xxx).
- R9: In normal mode the minus mark follows `minus_in`, and the high and low marks are off.
- R10: `annunc_out` is 1 throughout positive frames and 0 throughout negative frames. It therefore rises at the slot in which backplane 0 is driven to 3.
- R11: While the buzzer is active, `buzz_out` has a period of BUZ_DIV clocks (default 8). It is 0 for the first half of each period and 1 for the second half, counted from reset release. While inactive it is 0.
- R12: In logic-probe mode the leading digit and the next digit are blank. Digit `[7:4]` shows O (a,b,c,d,e,f) and digit `[3:0]` shows L (d,e,f). All decimal points and the minus mark are off. The high mark follows `dp_sel[1]` and the low mark follows `dp_sel[0]`.
- R13: The buzzer is active when `buzz_req` is high, or when logic-probe mode is on and `dp_sel[0]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 16 | Four BCD digits, leading digit in the top nibble |
| dp_sel | input | 2 | Decimal-point code; low/high probe inputs in probe mode |
| minus_in | input | 1 | Negative reading sign |
| over_flag | input | 1 | Over-range mark |
| peak_flag | input | 1 | Peak-hold mark |
| batt_flag | input | 1 | Low-battery mark |
| probe_mode | input | 1 | Logic-probe display mode |
| buzz_req | input | 1 | External buzzer request |
| bp_code | output | 6 | Level codes of the three backplanes |
| seg_code | output | 24 | Level codes of the twelve segment lines |
| annunc_out | output | 1 | Square wave in phase with backplane 0 |
| buzz_out | output | 1 | Buzzer tone |

## Verification
On every cycle the assertions check several properties of the drive waveform. Exactly one backplane sits at an extreme level. All segment codes share the parity that `annunc_out` implies for the frame. `annunc_out` rises only while backplane 0 is selected high. The buzzer stays silent unless its OR condition holds, and probe mode keeps every decimal-point line at its off level. Only the bench's scenarios can show the exact slot and frame counts, the line/slot map, the digit patterns and blanking rules, the decimal-point decode and the buzzer phase. To do this, it replays the expected on/off map against an independent cycle count.

// File: rtl/lcd_tri_pkg.sv
package lcd_tri_pkg;

    localparam int NUM_BP    = 3;
    localparam int NUM_LINES = 12;
    localparam int NUM_SEGS  = 7;

    typedef enum logic [1:0] {
        LV0 = 2'd0,
        LV1 = 2'd1,
        LV2 = 2'd2,
        LV3 = 2'd3
    } lvl_t;

    typedef struct packed {
        logic       neg_frame;
        logic [1:0] slot;
    } phase_t;

    typedef logic [NUM_SEGS-1:0] segs_t;  // {a,b,c,d,e,f,g}

    function automatic segs_t seg7(input logic [3:0] v);
        case (v)
            4'd0:    seg7 = 7'b1111110;
            4'd1:    seg7 = 7'b0110000;
            4'd2:    seg7 = 7'b1101101;
            4'd3:    seg7 = 7'b1111001;
            4'd4:    seg7 = 7'b0110011;
            4'd5:    seg7 = 7'b1011011;
            4'd6:    seg7 = 7'b1011111;
            4'd7:    seg7 = 7'b1110000;
            4'd8:    seg7 = 7'b1111111;
            4'd9:    seg7 = 7'b1111011;
            default: seg7 = 7'b0000000;
        endcase
    endfunction

    function automatic segs_t lead_seg(input logic [3:0] v);
        lead_seg = (v >= 4'd1 && v <= 4'd3) ? seg7(v) : 7'b0000000;
    endfunction

    function automatic lvl_t bp_level(input logic active, input logic neg);
        if (active) bp_level = neg ? LV0 : LV3;
        else        bp_level = neg ? LV2 : LV1;
    endfunction

    function automatic lvl_t seg_level(input logic on, input logic neg);
        if (on) seg_level = neg ? LV3 : LV0;
        else    seg_level = neg ? LV1 : LV2;
    endfunction

endpackage

// File: rtl/lcd_tri_timing.sv
module lcd_tri_timing
    import lcd_tri_pkg::*;
#(
    parameter int SLOT_CYCLES = 40,
    parameter int BUZ_DIV     = 8
) (
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   tone
);
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam int BW = (BUZ_DIV > 1) ? $clog2(BUZ_DIV) : 1;

    logic [CW-1:0] cyc_q;
    logic [BW-1:0] tone_q;
    phase_t        ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            ph_q  <= '0;
        end else if (cyc_q == CW'(SLOT_CYCLES - 1)) begin
            cyc_q <= '0;
            if (ph_q.slot == 2'(NUM_BP - 1)) begin
                ph_q.slot      <= '0;
                ph_q.neg_frame <= ~ph_q.neg_frame;
            end else begin
                ph_q.slot <= ph_q.slot + 2'd1;
            end
        end else begin
            cyc_q <= cyc_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             tone_q <= '0;
        else if (tone_q == BW'(BUZ_DIV - 1)) tone_q <= '0;
        else                                 tone_q <= tone_q + BW'(1);
    end

    assign phase = ph_q;
    assign tone  = (tone_q >= BW'(BUZ_DIV / 2));
endmodule

// File: rtl/lcd_tri_segmap.sv
module lcd_tri_segmap
    import lcd_tri_pkg::*;
(
    input  logic [15:0]                  bcd_in,
    input  logic [1:0]                   dp_sel,
    input  logic                         minus_in,
    input  logic                         over_flag,
    input  logic                         peak_flag,
    input  logic                         batt_flag,
    input  logic                         probe_mode,
    output logic [NUM_LINES-1:0][NUM_BP-1:0] on_map
);
    localparam int LOW_DIGITS = 3;

    segs_t                         lead;
    logic [LOW_DIGITS-1:0][6:0]    lseg;
    logic [LOW_DIGITS-1:0]         mark;
    logic [LOW_DIGITS-1:0]         extra;
    logic                          dp1, dp2, dp3, lo_mark, hi_mark, minus_mark;

    assign lead       = probe_mode ? '0 : lead_seg(bcd_in[15:12]);
    assign dp1        = !probe_mode && (dp_sel == 2'b01);
    assign dp2        = !probe_mode && (dp_sel == 2'b10);
    assign dp3        = !probe_mode && (dp_sel == 2'b11);
    assign lo_mark    = probe_mode && dp_sel[0];
    assign hi_mark    = probe_mode && dp_sel[1];
    assign minus_mark = !probe_mode && minus_in;

    assign mark  = {peak_flag, over_flag, hi_mark};
    assign extra = {batt_flag, dp1, dp2};

    // leading digit lines; slot index is the array bit
    assign on_map[0] = {lead[2], minus_mark, lo_mark};
    assign on_map[1] = {lead[3], lead[0], lead[6]};
    assign on_map[2] = {dp3, lead[4], lead[5]};

    for (genvar g = 0; g < LOW_DIGITS; g++) begin : g_digit
        localparam int          NIB = 2 - g;
        localparam logic [6:0]  PP  = (g == 1) ? 7'b1111110 :
                                      (g == 2) ? 7'b0001110 : 7'b0000000;
        assign lseg[g] = probe_mode ? PP : seg7(bcd_in[4*NIB +: 4]);

        assign on_map[3 + 3*g] = {lseg[g][2], lseg[g][1], mark[g]};
        assign on_map[4 + 3*g] = {lseg[g][3], lseg[g][0], lseg[g][6]};
        assign on_map[5 + 3*g] = {extra[g], lseg[g][4], lseg[g][5]};
    end
endmodule

// File: rtl/lcd_tri_drive.sv
module lcd_tri_drive
    import lcd_tri_pkg::*;
(
    input  phase_t                           phase,
    input  logic [NUM_LINES-1:0][NUM_BP-1:0] on_map,
    output logic [NUM_BP-1:0][1:0]           bp_lv,
    output logic [NUM_LINES-1:0][1:0]        seg_lv
);
    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        assign bp_lv[k] = bp_level(phase.slot == 2'(k), phase.neg_frame);
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign seg_lv[l] = seg_level(on_map[l][phase.slot], phase.neg_frame);
    end
endmodule

// File: rtl/lcd_tri_mux.sv
module lcd_tri_mux
    import lcd_tri_pkg::*;
#(
    parameter int SLOT_CYCLES = 40,
    parameter int BUZ_DIV     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bcd_in,
    input  logic [1:0]  dp_sel,
    input  logic        minus_in,
    input  logic        over_flag,
    input  logic        peak_flag,
    input  logic        batt_flag,
    input  logic        probe_mode,
    input  logic        buzz_req,
    output logic [5:0]  bp_code,
    output logic [23:0] seg_code,
    output logic        annunc_out,
    output logic        buzz_out
);
    phase_t                           phase;
    logic                             tone;
    logic [NUM_LINES-1:0][NUM_BP-1:0] on_map;
    logic [NUM_BP-1:0][1:0]           bp_lv;
    logic [NUM_LINES-1:0][1:0]        seg_lv;
    logic                             buzz_active;

    lcd_tri_timing #(.SLOT_CYCLES(SLOT_CYCLES), .BUZ_DIV(BUZ_DIV)) u_timing (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .tone  (tone)
    );

    lcd_tri_segmap u_map (
        .bcd_in     (bcd_in),
        .dp_sel     (dp_sel),
        .minus_in   (minus_in),
        .over_flag  (over_flag),
        .peak_flag  (peak_flag),
        .batt_flag  (batt_flag),
        .probe_mode (probe_mode),
        .on_map     (on_map)
    );

    lcd_tri_drive u_drive (
        .phase  (phase),
        .on_map (on_map),
        .bp_lv  (bp_lv),
        .seg_lv (seg_lv)
    );

    assign buzz_active = buzz_req || (probe_mode && dp_sel[0]);
    assign bp_code     = bp_lv;
    assign seg_code    = seg_lv;
    assign annunc_out  = ~phase.neg_frame;
    assign buzz_out    = buzz_active && tone;
endmodule

// File: rtl/lcd_tri_checker.sv
module lcd_tri_checker (
    input logic        clk,
    input logic        rst,
    input logic        probe_mode,
    input logic [1:0]  dp_sel,
    input logic        buzz_req,
    input logic [5:0]  bp_code,
    input logic [23:0] seg_code,
    input logic        annunc_out,
    input logic        buzz_out
);
    logic [2:0]  bp_ext;
    logic        all_even, all_odd;
    logic [1:0]  off_lv;

    for (genvar k = 0; k < 3; k++) begin : g_ext
        assign bp_ext[k] = (bp_code[2*k +: 2] == 2'd0) || (bp_code[2*k +: 2] == 2'd3);
    end

    always_comb begin
        all_even = 1'b1;
        all_odd  = 1'b1;
        for (int l = 0; l < 12; l++) begin
            if (seg_code[2*l])  all_even = 1'b0;
            if (!seg_code[2*l]) all_odd  = 1'b0;
        end
    end

    assign off_lv = annunc_out ? 2'd2 : 2'd1;

    assert_one_bp_selected_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(bp_ext) == 1);

    assert_seg_parity_R4: assert property (@(posedge clk) disable iff (rst)
        annunc_out ? all_even : all_odd);

    assert_annunc_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(annunc_out) |-> bp_code[1:0] == 2'd3);

    assert_annunc_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(annunc_out) |-> bp_code[1:0] == 2'd0);

    assert_buzz_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !(buzz_req || (probe_mode && dp_sel[0])) |-> !buzz_out);

    assert_probe_no_dp_R12: assert property (@(posedge clk) disable iff (rst)
        (probe_mode && bp_ext[2]) |->
            (seg_code[5:4] == off_lv && seg_code[11:10] == off_lv && seg_code[17:16] == off_lv));
endmodule

bind lcd_tri_mux lcd_tri_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .probe_mode (probe_mode),
    .dp_sel     (dp_sel),
    .buzz_req   (buzz_req),
    .bp_code    (bp_code),
    .seg_code   (seg_code),
    .annunc_out (annunc_out),
    .buzz_out   (buzz_out)
);

// File: tb/test_lcd_tri_mux.sv
module test_lcd_tri_mux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bcd_in = '0;
    logic [1:0]  dp_sel = '0;
    logic        minus_in = 0, over_flag = 0, peak_flag = 0, batt_flag = 0;
    logic        probe_mode = 0, buzz_req = 0;
    logic [5:0]  bp_code;
    logic [23:0] seg_code;
    logic        annunc_out, buzz_out;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [35:0] on;
        logic        buz_act;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    bit   have = 0;

    always #5 clk = ~clk;

    lcd_tri_mux i_lcd_tri_mux (
        .clk(clk), .rst(rst), .bcd_in(bcd_in), .dp_sel(dp_sel),
        .minus_in(minus_in), .over_flag(over_flag), .peak_flag(peak_flag),
        .batt_flag(batt_flag), .probe_mode(probe_mode), .buzz_req(buzz_req),
        .bp_code(bp_code), .seg_code(seg_code),
        .annunc_out(annunc_out), .buzz_out(buzz_out)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, expv);
        end
    endtask

    // segment patterns {a,b,c,d,e,f,g}
    function automatic logic [6:0] pat(input logic [3:0] v);
        logic [6:0] r;
        r = 7'b0000000;
        if (v == 0) r = 7'b1111110;
        if (v == 1) r = 7'b0110000;
        if (v == 2) r = 7'b1101101;
        if (v == 3) r = 7'b1111001;
        if (v == 4) r = 7'b0110011;
        if (v == 5) r = 7'b1011011;
        if (v == 6) r = 7'b1011111;
        if (v == 7) r = 7'b1110000;
        if (v == 8) r = 7'b1111111;
        if (v == 9) r = 7'b1111011;
        return r;
    endfunction

    function automatic logic [35:0] build(input logic [15:0] b, input logic [1:0] dp,
        input logic mi, input logic ov, input logic pk, input logic bt, input logic pr);
        logic [6:0] m, d3, d2, d1;
        logic lo, hi, mn, p1, p2, p3;
        logic [35:0] r;
        if (pr) begin
            m = '0; d3 = '0; d2 = 7'b1111110; d1 = 7'b0001110;
            lo = dp[0]; hi = dp[1]; mn = 0; p1 = 0; p2 = 0; p3 = 0;
        end else begin
            m  = (b[15:12] >= 1 && b[15:12] <= 3) ? pat(b[15:12]) : 7'b0;
            d3 = pat(b[11:8]); d2 = pat(b[7:4]); d1 = pat(b[3:0]);
            lo = 0; hi = 0; mn = mi;
            p1 = (dp == 2'b01); p2 = (dp == 2'b10); p3 = (dp == 2'b11);
        end
        r = '0;
        // bit index = line*3 + slot; pattern bits a=6 b=5 c=4 d=3 e=2 f=1 g=0
        r[0]  = lo;  r[1]  = mn;    r[2]  = m[2];
        r[3]  = m[6]; r[4] = m[0];  r[5]  = m[3];
        r[6]  = m[5]; r[7] = m[4];  r[8]  = p3;
        r[9]  = hi;  r[10] = d3[1]; r[11] = d3[2];
        r[12] = d3[6]; r[13] = d3[0]; r[14] = d3[3];
        r[15] = d3[5]; r[16] = d3[4]; r[17] = p2;
        r[18] = ov;  r[19] = d2[1]; r[20] = d2[2];
        r[21] = d2[6]; r[22] = d2[0]; r[23] = d2[3];
        r[24] = d2[5]; r[25] = d2[4]; r[26] = p1;
        r[27] = pk;  r[28] = d1[1]; r[29] = d1[2];
        r[30] = d1[6]; r[31] = d1[0]; r[32] = d1[3];
        r[33] = d1[5]; r[34] = d1[4]; r[35] = bt;
        return r;
    endfunction

    task automatic apply(input logic [15:0] b, input logic [1:0] dp, input logic mi,
        input logic ov, input logic pk, input logic bt, input logic pr, input logic bq,
        input string tag, input int hold);
        exp_t e;
        @(negedge clk);
        bcd_in = b; dp_sel = dp; minus_in = mi; over_flag = ov; peak_flag = pk;
        batt_flag = bt; probe_mode = pr; buzz_req = bq;
        e.on = build(b, dp, mi, ov, pk, bt, pr);
        e.buz_act = bq | (pr & dp[0]);
        e.tag = tag;
        q.push_back(e);
        repeat (hold) @(negedge clk);
    endtask

    // monitor: independent cycle count since reset release
    initial begin
        int  cnt;
        bit  rs;
        cnt = 0;
        forever begin
            @(posedge clk);
            rs = rst;
            #2;
            if (rs) cnt = 0; else cnt++;
            if (q.size() > 0) begin
                cur  = q.pop_front();
                have = 1;
            end
            if (have) begin
                int p, slot;
                bit negf;
                logic [5:0]  ebp;
                logic [23:0] eseg;
                p    = cnt % 240;
                negf = (p >= 120);
                slot = (p % 120) / 40;
                for (int k = 0; k < 3; k++)
                    ebp[2*k +: 2] = (k == slot) ? (negf ? 2'd0 : 2'd3) : (negf ? 2'd2 : 2'd1);
                for (int l = 0; l < 12; l++) begin
                    bit on;
                    on = cur.on[l*3 + slot];
                    eseg[2*l +: 2] = negf ? (on ? 2'd3 : 2'd1) : (on ? 2'd0 : 2'd2);
                end
                if (rs) begin
                    check(bp_code == 6'b01_01_11, "R1 reset backplanes", 36'(bp_code), 36'(6'b010111));
                    check(buzz_out == 1'b0, "R1 reset buzzer", 36'(buzz_out), 36'd0);
                end
                check(bp_code == ebp, "R2 R3 backplane", 36'(bp_code), 36'(ebp));
                check(seg_code == eseg, {"R4 segments ", cur.tag}, 36'(seg_code), 36'(eseg));
                check(annunc_out == !negf, "R10 annunciator", 36'(annunc_out), 36'(!negf));
                check(buzz_out == (cur.buz_act && ((cnt % 8) >= 4)), {"R11 buzzer ", cur.tag},
                      36'(buzz_out), 36'(cur.buz_act && ((cnt % 8) >= 4)));
            end
        end
    end

    initial begin
        #3_000_000;
        n_fails++;
        $display("FAIL R2 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        exp_t e0;
        e0.on = build(16'h0000, 2'b00, 0, 0, 0, 0, 0);
        e0.buz_act = 0;
        e0.tag = "R1 R7 zero reading";
        q.push_back(e0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (480) @(negedge clk);
        apply(16'h3210, 2'b01, 1, 0, 0, 0, 0, 0, "R6 R7 R8 R9 3210", 480);
        apply(16'h1985, 2'b11, 0, 1, 0, 0, 0, 0, "R5 R8 1985 over", 480);
        apply(16'h0467, 2'b10, 0, 0, 1, 1, 0, 0, "R5 R7 R8 0467 peak batt", 480);
        apply(16'h5ABC, 2'b00, 1, 0, 0, 0, 0, 0, "R6 R7 blanking", 480);
        apply(16'h2222, 2'b00, 0, 0, 0, 0, 0, 1, "R11 R13 external buzzer", 480);
        apply(16'h3333, 2'b10, 1, 0, 0, 0, 1, 0, "R12 probe high", 480);
        apply(16'h3333, 2'b01, 1, 1, 0, 0, 1, 0, "R12 R13 probe low", 480);
        apply(16'h0987, 2'b11, 0, 0, 1, 0, 1, 0, "R12 probe both", 480);
        apply(16'h0987, 2'b01, 0, 0, 0, 1, 0, 0, "R13 R9 normal mode dp code", 480);
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule